// File: doc/BRIEF.md
# Bus Hold Handshake Sequencer

This block produces the bus-cycle control of a small 8-bit processor that has a 16-bit address space. Each transfer is one machine cycle of three clock states. In the first state the address latch strobe is pulsed and the address is presented. In the second and third states the read or write strobe is active. Extra whole-clock wait states are added between the second and third states while the ready input is low. Transfers come from a simple command port. The port carries a valid flag, a write flag, an I/O-versus-memory flag, an address and write data. A command that is present when the sequencer is at a cycle boundary starts a new cycle on the next rising edge.

An external bus master asks for the bus by raising the hold input. The sequencer never gives up the bus in the middle of a cycle. It raises the hold acknowledge during the last state of the running cycle. The address, data and control drivers are disabled on the falling clock edge that follows, which is half a clock after the acknowledge rises. The acknowledge stays high for as long as hold is held high. After hold drops, the acknowledge falls on the next rising edge, the drivers come back on the following falling edge, and the next cycle may start at once. An active-low reset disables all drivers and clears the acknowledge. While reset is active, a reset-out signal is driven high; it is released on the first rising clock edge after reset is removed.

Top module: `bus_hold_seq`

## Requirements
- R1: A cycle starts with one clock of state T1, in which `ale` is 1 and `addrOut`/`ioM` show the accepted command's address and I/O flag (`ioM`=1 means I/O). `ale` is 0 in every other state.
- R2: In a read cycle `rdN` is 0 in T2, in every wait state and in T3, and 1 otherwise. `wrN` behaves the same way for write cycles. The two are never 0 together.
- R3: At the end of T2 or of a wait state, when `ready` is 0 on the rising edge, one more whole-clock wait state follows. T3 follows the first rising edge that sees `ready` at 1.
- R4: When `hold` is 1 on the rising edge that ends T2 or a wait state, the cycle still completes, and `hlda` is 1 during its T3.
- R5: `addrOe`, `dataOe` and `ctrlOe` fall on the first falling clock edge after `hlda` rises, and not before it.
- R6: `hlda` stays 1 while `hold` stays 1. On the first rising edge that sees `hold` at 0, `hlda` falls. The drivers are enabled again from the next falling edge, and a pending command enters T1 on that same rising edge.
- R7: When `hold` is 1 on the rising edge that ends T3, or on a rising edge while idle, the bus is granted on that edge (`hlda` rises) and no new cycle starts.
- R8: While `rstN` is 0, `hlda` is 0, all three output enables are 0 and `resetOut` is 1, all without waiting for a clock. `resetOut` falls on the first rising edge after `rstN` returns to 1.
- R9: A command that is valid on the rising edge that ends T3 enters T1 on that edge, with no idle state in between.
- R10: `dataOe` is 1 only during T2, wait states and T3 of a write cycle while the bus is not floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ready | input | 1 | 0 requests a wait state |
| hold | input | 1 | External master requests the bus |
| cmdValid | input | 1 | Command present; taken at a cycle boundary |
| cmdWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| cmdIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cmdAddr | input | 16 | Cycle address |
| cmdWdata | input | 8 | Write data |
| addrOut | output | 16 | Latched address |
| dataOut | output | 8 | Latched write data |
| ale | output | 1 | Address latch strobe (T1) |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| ioM | output | 1 | I/O (1) or memory (0) cycle |
| hlda | output | 1 | Hold acknowledge |
| addrOe | output | 1 | Address driver enable |
| dataOe | output | 1 | Data driver enable |
| ctrlOe | output | 1 | Control driver enable |
| resetOut | output | 1 | Reset indication, released on a clock edge |

## Verification
A wrong state code shows at once in the strobes. The bench checks the values in every state, so a skipped or extra state makes `ale`, `rdN` or `wrN` differ from the expected value within one clock. A mistake in the grant path shows as `hlda` rising one state early or late. A mistake in the half-clock float shows as an output enable that changes on the wrong edge. The bench samples both just after the rising edge and after the falling edge, so it sees the error within half a clock.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_HOLD = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture command on this rising edge
    logic ale;        // T1
    logic dataPhase;  // T2, wait or T3
    logic hlda;       // grant flag
  } seqStrobe_t;
endpackage

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bus_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ready,
  input  logic       hold,
  input  logic       cmdValid,
  output seqStrobe_t strobe
);
  seqState_e stateQ, stateNxt;
  logic hldaQ, hldaNxt, loadNxt;

  always_comb begin
    stateNxt = stateQ;
    hldaNxt  = hldaQ;
    loadNxt  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (hold) begin
          stateNxt = ST_HOLD;
          hldaNxt  = 1'b1;
        end else if (cmdValid) begin
          stateNxt = ST_T1;
          loadNxt  = 1'b1;
        end
      end
      ST_T1: stateNxt = ST_T2;
      ST_T2, ST_TW: begin
        if (ready) begin
          stateNxt = ST_T3;
          hldaNxt  = hold;
        end else begin
          stateNxt = ST_TW;
        end
      end
      ST_T3: begin
        if (hldaQ || hold) begin
          stateNxt = ST_HOLD;
          hldaNxt  = 1'b1;
        end else if (cmdValid) begin
          stateNxt = ST_T1;
          loadNxt  = 1'b1;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!hold) begin
          hldaNxt = 1'b0;
          if (cmdValid) begin
            stateNxt = ST_T1;
            loadNxt  = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      default: begin
        stateNxt = ST_IDLE;
        hldaNxt  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      hldaQ  <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      hldaQ  <= hldaNxt;
    end
  end

  always_comb begin
    strobe.load      = loadNxt;
    strobe.ale       = (stateQ == ST_T1);
    strobe.dataPhase = (stateQ == ST_T2) || (stateQ == ST_TW) || (stateQ == ST_T3);
    strobe.hlda      = hldaQ;
  end
endmodule

// File: rtl/bus_hold_dp.sv
module bus_hold_dp
  import bus_hold_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmdWrite,
  input  logic              cmdIo,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              hlda,
  output logic              addrOe,
  output logic              dataOe,
  output logic              ctrlOe,
  output logic              resetOut
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic writeQ, ioQ, busFloatQ, resetOutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= cmdAddr;
      dataQ  <= cmdWdata;
      writeQ <= cmdWrite;
      ioQ    <= cmdIo;
    end
  end

  // half-clock float: falling-edge copy of the grant flag
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) busFloatQ <= 1'b1;
    else       busFloatQ <= strobe.hlda;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetOutQ <= 1'b1;
    else       resetOutQ <= 1'b0;
  end

  assign addrOut  = addrQ;
  assign dataOut  = dataQ;
  assign ioM      = ioQ;
  assign ale      = strobe.ale;
  assign rdN      = !(strobe.dataPhase && !writeQ);
  assign wrN      = !(strobe.dataPhase && writeQ);
  assign hlda     = strobe.hlda;
  assign addrOe   = !busFloatQ;
  assign ctrlOe   = !busFloatQ;
  assign dataOe   = !busFloatQ && strobe.dataPhase && writeQ;
  assign resetOut = resetOutQ;
endmodule

// File: rtl/bus_hold_seq.sv
module bus_hold_seq
  import bus_hold_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ready,
  input  logic              hold,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic              cmdIo,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              hlda,
  output logic              addrOe,
  output logic              dataOe,
  output logic              ctrlOe,
  output logic              resetOut
);
  seqStrobe_t strobe;

  bus_hold_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ready    (ready),
    .hold     (hold),
    .cmdValid (cmdValid),
    .strobe   (strobe)
  );

  bus_hold_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdWrite (cmdWrite),
    .cmdIo    (cmdIo),
    .cmdAddr  (cmdAddr),
    .cmdWdata (cmdWdata),
    .addrOut  (addrOut),
    .dataOut  (dataOut),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .ioM      (ioM),
    .hlda     (hlda),
    .addrOe   (addrOe),
    .dataOe   (dataOe),
    .ctrlOe   (ctrlOe),
    .resetOut (resetOut)
  );
endmodule

// File: rtl/bus_hold_seq_chk.sv
module bus_hold_seq_chk (
  input logic clk,
  input logic rstN,
  input logic hold,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic hlda,
  input logic addrOe,
  input logic dataOe
);
  a_r1_ale_single: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    rdN || wrN);
  a_r7_no_ale_granted: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !ale);
  a_r5_floated: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && $past(hlda)) |-> !addrOe);
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && !hold) |=> !hlda);
  a_r10_data_write: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !wrN);
endmodule

bind bus_hold_seq bus_hold_seq_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .hold   (hold),
  .ale    (ale),
  .rdN    (rdN),
  .wrN    (wrN),
  .hlda   (hlda),
  .addrOe (addrOe),
  .dataOe (dataOe)
);

// File: tb/bus_hold_seq_bench.sv
module bus_hold_seq_bench;
  logic clk = 1'b0;
  logic rstN, ready, hold, cmdValid, cmdWrite, cmdIo;
  logic [15:0] cmdAddr, addrOut;
  logic [7:0]  cmdWdata, dataOut;
  logic ale, rdN, wrN, ioM, hlda, addrOe, dataOe, ctrlOe, resetOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_hold_seq u_bus_hold_seq (
    .clk(clk), .rstN(rstN), .ready(ready), .hold(hold),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdIo(cmdIo),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .addrOut(addrOut), .dataOut(dataOut), .ale(ale), .rdN(rdN), .wrN(wrN),
    .ioM(ioM), .hlda(hlda), .addrOe(addrOe), .dataOe(dataOe),
    .ctrlOe(ctrlOe), .resetOut(resetOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lands 6 ns after a rising edge (after the falling edge)
  task automatic tick();
    @(posedge clk); #6;
  endtask

  task automatic issue(input logic wr, input logic io, input logic [15:0] a, input logic [7:0] d);
    cmdValid = 1'b1; cmdWrite = wr; cmdIo = io; cmdAddr = a; cmdWdata = d;
  endtask

  task automatic tReset();
    rstN = 1'b0; ready = 1'b1; hold = 1'b0; cmdValid = 1'b0;
    cmdWrite = 1'b0; cmdIo = 1'b0; cmdAddr = '0; cmdWdata = '0;
    tick(); tick();
    chk("R8 resetOut in reset", resetOut, 1);
    chk("R8 hlda in reset", hlda, 0);
    chk("R8 addrOe in reset", addrOe, 0);
    chk("R8 ctrlOe in reset", ctrlOe, 0);
    rstN = 1'b1;
    tick();
    chk("R8 resetOut released", resetOut, 0);
    chk("R8 addrOe driven", addrOe, 1);
  endtask

  task automatic tRead();
    issue(1'b0, 1'b1, 16'h1234, 8'h00);
    tick();
    cmdValid = 1'b0;
    chk("R1 ale in T1", ale, 1);
    chk("R1 address", addrOut, 16'h1234);
    chk("R1 ioM", ioM, 1);
    chk("R2 rdN high in T1", rdN, 1);
    tick();
    chk("R1 ale low in T2", ale, 0);
    chk("R2 rdN T2", rdN, 0);
    chk("R10 no dataOe on read", dataOe, 0);
    tick();
    chk("R2 rdN T3", rdN, 0);
    chk("R2 wrN idle in read", wrN, 1);
    tick();
    chk("R2 rdN after cycle", rdN, 1);
  endtask

  task automatic tWait();
    int lowCnt = 0;
    issue(1'b0, 1'b0, 16'h00a5, 8'h00);
    tick();
    cmdValid = 1'b0;
    ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      if (!rdN) lowCnt++;
      chk("R3 ale low in wait", ale, 0);
    end
    ready = 1'b1;
    tick();
    if (!rdN) lowCnt++;
    tick();
    chk("R3 rdN released after wait", rdN, 1);
    chk("R3 read strobe length", lowCnt, 4);
  endtask

  task automatic tHoldMid();
    issue(1'b1, 1'b0, 16'hbeef, 8'h5a);
    tick();
    cmdValid = 1'b0;
    hold = 1'b1;
    tick();
    chk("R4 no grant in T2", hlda, 0);
    chk("R2 wrN T2", wrN, 0);
    chk("R10 dataOe T2 write", dataOe, 1);
    chk("R10 data value", dataOut, 8'h5a);
    @(posedge clk); #2;
    chk("R4 hlda in T3", hlda, 1);
    chk("R4 wrN in T3", wrN, 0);
    chk("R5 addrOe before falling edge", addrOe, 1);
    #4;
    chk("R5 addrOe floated", addrOe, 0);
    chk("R5 ctrlOe floated", ctrlOe, 0);
    chk("R5 dataOe floated", dataOe, 0);
    tick();
    chk("R6 hlda held", hlda, 1);
    chk("R6 no ale in hold", ale, 0);
    tick();
    chk("R6 hlda still held", hlda, 1);
    hold = 1'b0;
    issue(1'b0, 1'b0, 16'h0042, 8'h00);
    @(posedge clk); #2;
    chk("R6 hlda dropped", hlda, 0);
    chk("R6 pending T1", ale, 1);
    chk("R6 still floated before falling edge", addrOe, 0);
    #4;
    cmdValid = 1'b0;
    chk("R6 address driven again", addrOe, 1);
    tick(); tick(); tick();
    chk("R6 cycle done", rdN, 1);
  endtask

  task automatic tHoldLate();
    issue(1'b0, 1'b0, 16'h0100, 8'h00);
    tick();
    cmdValid = 1'b0;
    tick(); tick();
    chk("R7 no grant in T3", hlda, 0);
    hold = 1'b1;
    tick();
    chk("R7 granted at boundary", hlda, 1);
    chk("R7 floated", addrOe, 0);
    chk("R7 rdN released", rdN, 1);
    hold = 1'b0;
    tick();
    chk("R6 release", hlda, 0);
    hold = 1'b1;
    tick();
    chk("R7 idle grant", hlda, 1);
    hold = 1'b0;
    tick();
    chk("R7 idle release", hlda, 0);
  endtask

  task automatic tBackToBack();
    issue(1'b1, 1'b1, 16'h7000, 8'h11);
    tick();
    cmdValid = 1'b0;
    tick();
    issue(1'b0, 1'b0, 16'h7001, 8'h00);
    tick();
    chk("R9 wrN in T3", wrN, 0);
    chk("R9 ale low in T3", ale, 0);
    tick();
    cmdValid = 1'b0;
    chk("R9 direct T1", ale, 1);
    chk("R9 new address", addrOut, 16'h7001);
    chk("R9 ioM memory", ioM, 0);
    chk("R9 wrN off", wrN, 1);
    tick();
    chk("R9 read T2", rdN, 0);
    tick(); tick();
  endtask

  task automatic tResetInHold();
    hold = 1'b1;
    tick();
    chk("R7 grant before reset", hlda, 1);
    rstN = 1'b0;
    #1;
    chk("R8 async hlda clear", hlda, 0);
    chk("R8 async resetOut", resetOut, 1);
    chk("R8 async float", addrOe, 0);
    hold = 1'b0;
    #1;
    tick();
    rstN = 1'b1;
    tick();
    chk("R8 resetOut after release", resetOut, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tRead();
    tWait();
    tHoldMid();
    tHoldLate();
    tBackToBack();
    tResetInHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule